// File: doc/BRIEF.md
# Dual-Port RAM With Write Inhibit

This block is a clocked two-port memory of 2048 words by 8 bits. A left and a right port each carry an active-low select, a write strobe (low means write, high means read), an active-low output enable, an 11-bit address and 8-bit write data. Both ports may read or write any word in any cycle, with no coordination between them. A write takes effect at the rising clock edge. Read data is registered and appears one cycle after the request, together with a drive flag that stands in for a three-state output buffer and a "sure" flag that tells whether the returned word can be trusted.

Each port also has an active-low busy indication that silently drops that port's writes. The `MASTER` parameter sets where busy comes from. In master mode a small arbiter detects two selected ports on the same address and marks one of them busy. The block then exports that decision on its busy outputs, and the busy inputs are ignored. In slave mode there is no arbiter: the busy inputs act only as write inhibits and are echoed on the busy outputs. One master and any number of slaves can therefore share one address range to form a wider word, and every slice drops the same port's write.

The arbiter is a three-state machine. FREE means no contention is active. LEFT_HOLDS means the left port owns the contested word and the right port is busy. RIGHT_HOLDS is the mirror case. The transitions are as follows. FREE moves to LEFT_HOLDS on a new clash, unless only the right port had already been selected at that address in the previous cycle, in which case FREE moves to RIGHT_HOLDS. LEFT_HOLDS and RIGHT_HOLDS stay put while the clash lasts and return to FREE when it ends. The busy outputs decode the state chosen for the current cycle, so a write that arrives with the clash is already blocked.

Top module: `twin_port_ram`

## Requirements
- R1: A port with select low and write strobe low stores its write data at the addressed word at the clock edge, and a later read of that word returns it. This holds only when the port is not busy.
- R2: A port with select low, write strobe high and output enable low raises its drive flag in the next cycle and shows the word its address held at the sampling edge. In every other control combination, the next cycle shows drive low and read data 0.
- R3: A port whose select is high writes nothing and drives nothing in the next cycle, whatever its write strobe and output enable are.
- R4: When a port's busy indication is active (low), a write from that port leaves the memory unchanged.
- R5: In slave mode each busy output equals the corresponding busy input. In master mode the busy inputs have no effect on writes or on the busy outputs.
- R6: In master mode a busy output goes low only while both ports are selected at the same address, and never on both ports at once.
- R7: In master mode, when a clash begins, the port that was already selected at that address in the previous cycle wins and the other port is marked busy. If both ports arrive in the same cycle, the left port wins and the right port is marked busy.
- R8: In master mode the winner does not change while the clash continues.
- R9: The sure flag follows the drive flag, except that it is low for a read sampled while that port was busy.
- R10: A read on one port of the word being written by the other port in the same cycle returns the old contents, and the new data is returned from the next cycle on.
- R11: If both ports write the same word in one cycle and neither port is busy (possible only in slave mode), the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sel_n | input | 1 | Left port select, active low |
| l_wr_n | input | 1 | Left strobe: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy indication, active low |
| l_rdata | output | 8 | Left read data, 0 when not driven |
| l_drive | output | 1 | Left read data is driven |
| l_sure | output | 1 | Left read data is guaranteed |
| r_sel_n | input | 1 | Right port select, active low |
| r_wr_n | input | 1 | Right strobe: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n | output | 1 | Right busy indication, active low |
| r_rdata | output | 8 | Right read data, 0 when not driven |
| r_drive | output | 1 | Right read data is driven |
| r_sure | output | 1 | Right read data is guaranteed |

## Verification
Arbitration and a memory access can fall in the same cycle. When a write arrives on the losing side, the busy decision must already block it at that edge, and a read on the losing side must still return the word with its sure flag low. A master-mode vector table provokes this in three ways: a late arrival, a simultaneous arrival and a held clash. Each vector is judged first at the busy outputs just after the inputs settle, and then one cycle later at the read outputs against a reference array that applied only the unblocked writes. A slave instance covers a read on one port and a write on the other to the same word in one cycle, where the old word must come back.

// File: rtl/twp_pkg.sv
package twp_pkg;

    typedef enum logic [1:0] {
        ARB_FREE        = 2'd0,
        ARB_LEFT_HOLDS  = 2'd1,
        ARB_RIGHT_HOLDS = 2'd2
    } arb_state_e;

endpackage

// File: rtl/twp_arbiter.sv
module twp_arbiter
    import twp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              r_sel_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy,
    output logic              r_busy
);

    arb_state_e state_q, state_nx;

    logic              l_was_sel, r_was_sel;
    logic [ADDR_W-1:0] l_was_addr, r_was_addr;
    logic              clash, l_settled, r_settled;

    assign clash     = !l_sel_n && !r_sel_n && (l_addr == r_addr);
    assign l_settled = l_was_sel && (l_was_addr == l_addr);
    assign r_settled = r_was_sel && (r_was_addr == r_addr);

    // history of each port, used to find the earlier arrival
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_was_sel  <= 1'b0;
            r_was_sel  <= 1'b0;
            l_was_addr <= '0;
            r_was_addr <= '0;
        end else begin
            l_was_sel  <= !l_sel_n;
            r_was_sel  <= !r_sel_n;
            l_was_addr <= l_addr;
            r_was_addr <= r_addr;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (clash) begin
                    if (r_settled && !l_settled) state_nx = ARB_RIGHT_HOLDS;
                    else                         state_nx = ARB_LEFT_HOLDS;
                end
            end
            ARB_LEFT_HOLDS: begin
                if (!clash) state_nx = ARB_FREE;
            end
            ARB_RIGHT_HOLDS: begin
                if (!clash) state_nx = ARB_FREE;
            end
            default: state_nx = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_FREE;
        else        state_q <= state_nx;
    end

    // outputs decode the decision taken for the present cycle
    always_comb begin
        l_busy = 1'b0;
        r_busy = 1'b0;
        unique case (state_nx)
            ARB_FREE:        ;
            ARB_LEFT_HOLDS:  r_busy = 1'b1;
            ARB_RIGHT_HOLDS: l_busy = 1'b1;
            default:         ;
        endcase
    end

    p_one_side_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy && r_busy));

    p_busy_needs_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy || r_busy) |-> (!l_sel_n && !r_sel_n && l_addr == r_addr));

    p_winner_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(r_busy) && !l_sel_n && !r_sel_n && l_addr == r_addr)
        |-> r_busy);

    p_early_left_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !l_sel_n && !r_sel_n && l_addr == r_addr &&
         !$past(l_sel_n) && $past(l_addr) == l_addr &&
         !(!$past(r_sel_n) && $past(r_addr) == r_addr)) |-> !l_busy);

endmodule

// File: rtl/twp_store.sv
module twp_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_q,
    output logic [DATA_W-1:0] r_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // left write placed last so it overrides an equal-address right write
    always_ff @(posedge clk) begin
        if (r_we) cells[r_addr] <= r_wdata;
        if (l_we) cells[l_addr] <= l_wdata;
        l_q <= cells[l_addr];
        r_q <= cells[r_addr];
    end

endmodule

// File: rtl/twp_port.sv
module twp_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] q,
    output logic              we,
    output logic [DATA_W-1:0] rdata,
    output logic              drive,
    output logic              sure
);

    logic rd_req;

    assign rd_req = !sel_n && wr_n && !oe_n;
    assign we     = !sel_n && !wr_n && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
            sure  <= 1'b0;
        end else begin
            drive <= rd_req;
            sure  <= rd_req && !busy;
        end
    end

    assign rdata = drive ? q : '0;

    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !oe_n) |=> drive);

    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!drive && rdata == '0));

    p_busy_read_unsure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sure);

    p_sure_needs_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sure |-> drive);

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter bit MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in_n,
    output logic              l_busy_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_drive,
    output logic              l_sure,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in_n,
    output logic              r_busy_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_drive,
    output logic              r_sure
);

    logic              l_busy, r_busy;
    logic              l_we, r_we;
    logic [DATA_W-1:0] l_q, r_q;

    generate
        if (MASTER) begin : g_master
            logic unused_busy_in;
            assign unused_busy_in = l_busy_in_n ^ r_busy_in_n;

            twp_arbiter #(.ADDR_W(ADDR_W)) u_arb (
                .clk     (clk),
                .rst_n   (rst_n),
                .l_sel_n (l_sel_n),
                .r_sel_n (r_sel_n),
                .l_addr  (l_addr),
                .r_addr  (r_addr),
                .l_busy  (l_busy),
                .r_busy  (r_busy)
            );
        end else begin : g_slave
            assign l_busy = !l_busy_in_n;
            assign r_busy = !r_busy_in_n;
        end
    endgenerate

    assign l_busy_n = !l_busy;
    assign r_busy_n = !r_busy;

    twp_port #(.DATA_W(DATA_W)) u_lport (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (l_sel_n),
        .wr_n  (l_wr_n),
        .oe_n  (l_oe_n),
        .busy  (l_busy),
        .q     (l_q),
        .we    (l_we),
        .rdata (l_rdata),
        .drive (l_drive),
        .sure  (l_sure)
    );

    twp_port #(.DATA_W(DATA_W)) u_rport (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (r_sel_n),
        .wr_n  (r_wr_n),
        .oe_n  (r_oe_n),
        .busy  (r_busy),
        .q     (r_q),
        .we    (r_we),
        .rdata (r_rdata),
        .drive (r_drive),
        .sure  (r_sure)
    );

    twp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .l_we    (l_we),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .r_we    (r_we),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .l_q     (l_q),
        .r_q     (r_q)
    );

    p_slave_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !MASTER |-> (l_busy_n == l_busy_in_n && r_busy_n == r_busy_in_n));

endmodule

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NV = 14;
    localparam int VW = 46;

    // control codes {sel_n, wr_n, oe_n}
    localparam logic [2:0] C_WR   = 3'b001;
    localparam logic [2:0] C_WROE = 3'b000;
    localparam logic [2:0] C_RD   = 3'b010;
    localparam logic [2:0] C_NOE  = 3'b011;
    localparam logic [2:0] C_DSRD = 3'b110;
    localparam logic [2:0] C_IDLE = 3'b111;

    // {lctl, laddr, ldata, rctl, raddr, rdata, exp_lbusy, exp_rbusy}
    localparam logic [VW-1:0] VEC [NV] = '{
        {C_WR,   11'h005, 8'hA1, C_WR,   11'h7FF, 8'hB2, 1'b0, 1'b0},
        {C_RD,   11'h005, 8'h00, C_RD,   11'h7FF, 8'h00, 1'b0, 1'b0},
        {C_NOE,  11'h005, 8'h00, C_WROE, 11'h010, 8'hC3, 1'b0, 1'b0},
        {C_DSRD, 11'h010, 8'h00, C_RD,   11'h010, 8'h00, 1'b0, 1'b0},
        {C_WR,   11'h020, 8'h11, C_IDLE, 11'h020, 8'h00, 1'b0, 1'b0},
        {C_RD,   11'h020, 8'h00, C_WR,   11'h020, 8'h22, 1'b0, 1'b1},
        {C_RD,   11'h020, 8'h00, C_WR,   11'h020, 8'h33, 1'b0, 1'b1},
        {C_IDLE, 11'h020, 8'h00, C_RD,   11'h020, 8'h00, 1'b0, 1'b0},
        {C_WR,   11'h005, 8'h44, C_RD,   11'h005, 8'h00, 1'b0, 1'b1},
        {C_RD,   11'h005, 8'h00, C_IDLE, 11'h000, 8'h00, 1'b0, 1'b0},
        {C_IDLE, 11'h000, 8'h00, C_WR,   11'h040, 8'h55, 1'b0, 1'b0},
        {C_WR,   11'h040, 8'h66, C_RD,   11'h040, 8'h00, 1'b1, 1'b0},
        {C_RD,   11'h040, 8'h00, C_IDLE, 11'h040, 8'h00, 1'b0, 1'b0},
        {C_IDLE, 11'h000, 8'h00, C_IDLE, 11'h000, 8'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1;
    logic r_sel_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic m_lbi = 1'b0, m_rbi = 1'b0;
    logic s_lbi = 1'b1, s_rbi = 1'b1;

    logic          m_lbusy_n, m_rbusy_n, m_ldrv, m_rdrv, m_lsure, m_rsure;
    logic [DW-1:0] m_lrd, m_rrd;
    logic          s_lbusy_n, s_rbusy_n, s_ldrv, s_rdrv, s_lsure, s_rsure;
    logic [DW-1:0] s_lrd, s_rrd;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_m [1 << AW];

    always #2 clk = ~clk;

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_in_n(m_lbi), .l_busy_n(m_lbusy_n),
        .l_rdata(m_lrd), .l_drive(m_ldrv), .l_sure(m_lsure),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_in_n(m_rbi), .r_busy_n(m_rbusy_n),
        .r_rdata(m_rrd), .r_drive(m_rdrv), .r_sure(m_rsure)
    );

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b0)) u_slv (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_in_n(s_lbi), .l_busy_n(s_lbusy_n),
        .l_rdata(s_lrd), .l_drive(s_ldrv), .l_sure(s_lsure),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_in_n(s_rbi), .r_busy_n(s_rbusy_n),
        .r_rdata(s_rrd), .r_drive(s_rdrv), .r_sure(s_rsure)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_l(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        {l_sel_n, l_wr_n, l_oe_n} = c;
        l_addr  = a;
        l_wdata = d;
    endtask

    task automatic set_r(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        {r_sel_n, r_wr_n, r_oe_n} = c;
        r_addr  = a;
        r_wdata = d;
    endtask

    function automatic logic is_rd(input logic [2:0] c);
        return c == C_RD;
    endfunction

    function automatic logic is_wr(input logic [2:0] c);
        return c[2:1] == 2'b00;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [2:0]    lc, rc;
        logic [AW-1:0] la, ra;
        logic [DW-1:0] ld, rd, e_ld, e_rd;
        logic          elb, erb, e_ldrv, e_rdrv, e_ls, e_rs;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R6)
        chk("R2", "reset l_drive", 32'(m_ldrv), 32'd0);
        chk("R2", "reset l_rdata", 32'(m_lrd), 32'd0);
        chk("R9", "reset r_sure", 32'(m_rsure), 32'd0);
        chk("R6", "reset l_busy_n", 32'(m_lbusy_n), 32'd1);
        chk("R6", "reset r_busy_n", 32'(m_rbusy_n), 32'd1);

        // master vector table; busy inputs held active to show R5 (ignored)
        for (int i = 0; i < NV; i++) begin
            {lc, la, ld, rc, ra, rd, elb, erb} = VEC[i];
            set_l(lc, la, ld);
            set_r(rc, ra, rd);
            #1;
            chk("R6/R7/R8", $sformatf("vec %0d l_busy_n", i), 32'(m_lbusy_n), 32'(!elb));
            chk("R6/R7/R8", $sformatf("vec %0d r_busy_n", i), 32'(m_rbusy_n), 32'(!erb));
            e_ldrv = is_rd(lc);
            e_rdrv = is_rd(rc);
            e_ld   = e_ldrv ? ref_m[la] : '0;
            e_rd   = e_rdrv ? ref_m[ra] : '0;
            e_ls   = e_ldrv && !elb;
            e_rs   = e_rdrv && !erb;
            if (is_wr(rc) && !erb) ref_m[ra] = rd;
            if (is_wr(lc) && !elb) ref_m[la] = ld;
            @(negedge clk);
            chk("R2/R3", $sformatf("vec %0d l_drive", i), 32'(m_ldrv), 32'(e_ldrv));
            chk("R2/R3", $sformatf("vec %0d r_drive", i), 32'(m_rdrv), 32'(e_rdrv));
            chk("R1/R4", $sformatf("vec %0d l_rdata", i), 32'(m_lrd), 32'(e_ld));
            chk("R1/R4", $sformatf("vec %0d r_rdata", i), 32'(m_rrd), 32'(e_rd));
            chk("R9", $sformatf("vec %0d l_sure", i), 32'(m_lsure), 32'(e_ls));
            chk("R9", $sformatf("vec %0d r_sure", i), 32'(m_rsure), 32'(e_rs));
        end

        // slave directed tests
        set_l(C_WR, 11'h100, 8'h70); set_r(C_IDLE, 11'h000, 8'h00);
        @(negedge clk);
        s_lbi = 1'b0;
        set_l(C_WR, 11'h100, 8'h7F);
        #1;
        chk("R5", "slave l_busy_n echo", 32'(s_lbusy_n), 32'd0);
        chk("R5", "slave r_busy_n echo", 32'(s_rbusy_n), 32'd1);
        @(negedge clk);
        set_l(C_RD, 11'h100, 8'h00);
        @(negedge clk);
        chk("R4", "blocked write l_rdata", 32'(s_lrd), 32'h70);
        chk("R9", "busy read l_sure", 32'(s_lsure), 32'd0);
        chk("R9", "busy read l_drive", 32'(s_ldrv), 32'd1);
        s_lbi = 1'b1;
        @(negedge clk);
        chk("R9", "free read l_sure", 32'(s_lsure), 32'd1);

        set_l(C_WR, 11'h200, 8'hAA); set_r(C_WR, 11'h200, 8'hBB);
        @(negedge clk);
        set_l(C_RD, 11'h200, 8'h00); set_r(C_RD, 11'h200, 8'h00);
        @(negedge clk);
        chk("R11", "same word l_rdata", 32'(s_lrd), 32'hAA);
        chk("R11", "same word r_rdata", 32'(s_rrd), 32'hAA);

        set_l(C_IDLE, 11'h000, 8'h00); set_r(C_WR, 11'h300, 8'h10);
        @(negedge clk);
        set_l(C_WR, 11'h300, 8'h12); set_r(C_RD, 11'h300, 8'h00);
        @(negedge clk);
        chk("R10", "read during write old", 32'(s_rrd), 32'h10);
        set_l(3'b100, 11'h300, 8'hFF);
        @(negedge clk);
        chk("R10", "read after write new", 32'(s_rrd), 32'h12);
        chk("R3", "deselected l_drive", 32'(s_ldrv), 32'd0);
        set_l(C_IDLE, 11'h000, 8'h00);
        @(negedge clk);
        chk("R3", "deselected write dropped", 32'(s_rrd), 32'h12);

        set_r(C_IDLE, 11'h000, 8'h00);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule